// File: doc/BRIEF.md
# Eight-Times Polyphase Interpolating Low-Pass Filter

This block raises a sample stream by a factor of eight, for example from 8 kHz to 64 kHz. Its output matches what you would get by placing seven zero samples after every input sample and then running the result through a 96-tap low-pass FIR at the higher rate. The block never stores those zeros and never multiplies by them. The 96 coefficients are split into eight interleaved subsets of twelve. Each output uses one subset, selected by a phase counter, against the twelve most recent real input samples.

A new input sample is offered with a one-cycle `in_valid` pulse. It shifts into a twelve-entry history and sets the phase back to zero. Each pulse on `out_strobe` at the high rate starts one twelve-cycle sequential multiply-accumulate run for the current phase, and then the phase advances. The 40-bit sum is rounded to 1.15 format, saturated, and presented on `out_sample` with a one-cycle `out_valid` pulse. Coefficients are 1.15 values written one at a time through a simple write port. The factor-of-eight gain loss of zero insertion is made up in the coefficients themselves: with each subset summing to 1.0, a constant input comes out unchanged.

Top module: `interp8_fir`

## Requirements
- R1: After reset, `out_sample` is 0, `out_valid` is 0, and all coefficients and history entries are 0, so a strobe issued straight after reset produces 0.
- R2: With `coef_we` high, `coef_data` is stored as coefficient h[n], where n = `coef_addr` is between 0 and 95. A write with `coef_addr` of 96 or more changes no coefficient.
- R3: An `in_valid` pulse shifts `in_sample` into the history as x[0] (newest), moving older entries one place toward x[11]. It also sets the phase to 0.
- R4: An accepted strobe at phase p computes the sum over k = 0..11 of h[p+8k]·x[k]. The phase then advances to (p+1) mod 8.
- R5: The `out_valid` pulse lasts one cycle and appears 13 clock cycles after the clock edge that samples the strobe (12 multiply-accumulate cycles plus one output register). `out_sample` holds its value until the next result.
- R6: A strobe that arrives while a run is in progress is ignored. It produces no extra output and does not advance the phase.
- R7: When `in_valid` and an accepted strobe arrive in the same cycle, the new sample is written first. The output then uses phase 0 with the new sample, and the next strobe uses phase 1.
- R8: Rounding adds 2^14 to the sum and shifts it right arithmetically by 15, so exact halves round toward positive infinity.
- R9: A result above 32767 is output as 32767, and one below −32768 as −32768.
- R10: No gain shift is applied inside the block. When every phase subset sums to 32768 (1.0), a constant input is reproduced exactly.
- R11: A single input of −32768 followed by zero inputs produces outputs equal to −h[n] for n = 0..95, in order. This is the zero-stuffed impulse response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | One-cycle pulse: `in_sample` is a new low-rate sample |
| in_sample | input | 16 | Signed 1.15 input sample |
| out_strobe | input | 1 | High-rate request for the next output |
| out_sample | output | 16 | Signed 1.15 result, rounded and saturated |
| out_valid | output | 1 | One-cycle pulse: `out_sample` has been updated |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | 7 | Coefficient index n (0..95) |
| coef_data | input | 16 | Signed 1.15 coefficient value |

## Verification
The assertions check several things on every cycle:
- the phase sequencing: reset on a new sample, one step per accepted strobe, and the combined sample-with-strobe case;
- that a strobe arriving mid-run leaves the selected phase unchanged;
- that a run lasts exactly twelve accumulate cycles;
- that the end of a run leads to a single output pulse.

The arithmetic is visible only in the bench's scenarios, which compare output values against an independent model:
- subset selection and the full impulse response;
- rounding of exact halves;
- saturation in both directions;
- unity gain on a constant input;
- the ignored out-of-range coefficient writes.

// File: rtl/interp8_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the eight-times interpolating filter.
package interp8_pkg;
    // State of the sequential multiply-accumulate engine.
    typedef enum logic {
        RUN_IDLE = 1'b0,
        RUN_MAC  = 1'b1
    } run_state_e;

    // Default geometry shared by the sub-blocks.
    localparam int DEF_SAMPLE_W = 16;
    localparam int DEF_COEF_W   = 16;
    localparam int DEF_RATE     = 8;
    localparam int DEF_TAPS     = 12;
    localparam int DEF_ACC_W    = 40;
    localparam int DEF_FRAC_W   = 15;
endpackage

// File: rtl/interp8_coef_bank.sv
`timescale 1ns/1ps
// Coefficient storage, arranged as RATE phase subsets of TAPS entries.
// Flat index n maps to phase n % RATE and tap n / RATE, so the subset
// for phase p holds h[p], h[p+RATE], ... Any write index at or above
// RATE*TAPS matches no cell and is dropped. Assumes one write per cycle.
module interp8_coef_bank #(
    parameter int COEF_W = 16,
    parameter int RATE   = 8,
    parameter int TAPS   = 12,
    parameter int ADDR_W = 7,
    parameter int PH_W   = 3,
    parameter int TAP_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic signed [COEF_W-1:0] wr_data,
    input  logic [PH_W-1:0]          rd_phase,
    input  logic [TAP_W-1:0]         rd_tap,
    output logic signed [COEF_W-1:0] rd_coef
);
    logic signed [COEF_W-1:0] bank [RATE][TAPS];

    // Clear on reset; store a write into the one cell whose flat index matches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < RATE; p++) begin
                for (int k = 0; k < TAPS; k++) begin
                    bank[p][k] <= '0;
                end
            end
        end else if (wr_en) begin
            for (int p = 0; p < RATE; p++) begin
                for (int k = 0; k < TAPS; k++) begin
                    if (wr_addr == ADDR_W'(p + RATE * k)) begin
                        bank[p][k] <= wr_data;
                    end
                end
            end
        end
    end

    // Present the coefficient selected by the running phase and tap.
    always_comb begin
        rd_coef = bank[rd_phase][rd_tap];
    end
endmodule

// File: rtl/interp8_delay_line.sv
`timescale 1ns/1ps
// History of the TAPS most recent low-rate samples. Entry 0 is newest.
// Only real samples are stored; the zero-stuffed positions never exist.
module interp8_delay_line #(
    parameter int SAMPLE_W = 16,
    parameter int TAPS     = 12,
    parameter int TAP_W    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic signed [SAMPLE_W-1:0] push_data,
    input  logic [TAP_W-1:0]           rd_tap,
    output logic signed [SAMPLE_W-1:0] rd_sample
);
    logic signed [SAMPLE_W-1:0] hist [TAPS];

    // Shift the history by one place on each new sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TAPS; i++) begin
                hist[i] <= '0;
            end
        end else if (push) begin
            hist[0] <= push_data;
            for (int i = 1; i < TAPS; i++) begin
                hist[i] <= hist[i-1];
            end
        end
    end

    // Present the sample for the tap being accumulated.
    always_comb begin
        rd_sample = hist[rd_tap];
    end
endmodule

// File: rtl/interp8_mac_ctrl.sv
`timescale 1ns/1ps
// Phase counter and sequential multiply-accumulate engine.
// A strobe seen while idle latches the phase to use (zero if a new sample
// arrives in the same cycle), then runs TAPS accumulate cycles, one tap per
// cycle. A strobe seen while running is ignored. acc_done pulses on the
// cycle after the last product is added. Assumes new samples arrive only
// while idle.
module interp8_mac_ctrl
    import interp8_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int COEF_W   = 16,
    parameter int RATE     = 8,
    parameter int TAPS     = 12,
    parameter int ACC_W    = 40,
    parameter int PH_W     = 3,
    parameter int TAP_W    = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_push,
    input  logic                       strobe,
    input  logic signed [SAMPLE_W-1:0] sample,
    input  logic signed [COEF_W-1:0]   coef,
    output logic [PH_W-1:0]            rd_phase,
    output logic [PH_W-1:0]            next_phase,
    output logic [TAP_W-1:0]           rd_tap,
    output logic                       busy,
    output logic signed [ACC_W-1:0]    acc,
    output logic                       acc_done
);
    localparam int PROD_W = SAMPLE_W + COEF_W;

    run_state_e               state_q;
    logic [PH_W-1:0]          phase_q;
    logic [PH_W-1:0]          cur_q;
    logic [TAP_W-1:0]         tap_q;
    logic signed [ACC_W-1:0]  acc_q;
    logic                     done_q;
    logic                     start;
    logic                     last_tap;
    logic [PH_W-1:0]          phase_inc;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  prod_ext;

    // Decode the start condition, last tap and the wrapped phase step.
    always_comb begin
        start     = strobe && (state_q == RUN_IDLE);
        last_tap  = (tap_q == TAP_W'(TAPS - 1));
        phase_inc = (phase_q == PH_W'(RATE - 1)) ? '0 : phase_q + PH_W'(1);
    end

    // Multiply the current tap pair and sign-extend it to accumulator width.
    always_comb begin
        prod     = sample * coef;
        prod_ext = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};
    end

    // Track the output phase: a new sample rewinds it, a start advances it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            cur_q   <= '0;
        end else if (start) begin
            cur_q   <= in_push ? '0 : phase_q;
            phase_q <= in_push ? PH_W'(1 % RATE) : phase_inc;
        end else if (in_push) begin
            phase_q <= '0;
        end
    end

    // Sequence one run of TAPS accumulate cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RUN_IDLE;
            tap_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= (state_q == RUN_MAC) && last_tap;
            if (start) begin
                state_q <= RUN_MAC;
                tap_q   <= '0;
            end else if (state_q == RUN_MAC) begin
                if (last_tap) begin
                    state_q <= RUN_IDLE;
                    tap_q   <= '0;
                end else begin
                    tap_q <= tap_q + TAP_W'(1);
                end
            end
        end
    end

    // Clear the sum at start and add one product per running cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (start) begin
            acc_q <= '0;
        end else if (state_q == RUN_MAC) begin
            acc_q <= acc_q + prod_ext;
        end
    end

    // Drive the outputs from the registered state.
    always_comb begin
        rd_phase   = cur_q;
        next_phase = phase_q;
        rd_tap     = tap_q;
        busy       = (state_q == RUN_MAC);
        acc        = acc_q;
        acc_done   = done_q;
    end
endmodule

// File: rtl/interp8_round_sat.sv
`timescale 1ns/1ps
// Output stage. Rounds the wide sum to OUT_W bits by adding half an LSB
// and shifting right arithmetically by FRAC_W, clamps the result to the
// OUT_W signed range and registers it with a one-cycle valid pulse.
// Assumes FRAC_W >= 0 and ACC_W is wide enough that the rounding add
// cannot overflow.
module interp8_round_sat #(
    parameter int ACC_W  = 40,
    parameter int OUT_W  = 16,
    parameter int FRAC_W = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic signed [ACC_W-1:0] acc,
    output logic signed [OUT_W-1:0] out_sample,
    output logic                    out_valid
);
    localparam logic signed [ACC_W-1:0] MAX_V = ACC_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] MIN_V = -ACC_W'(2 ** (OUT_W - 1));

    logic signed [ACC_W-1:0] scaled;
    logic signed [OUT_W-1:0] clamped;

    // Choose the rounding step to match the fractional shift.
    generate
        if (FRAC_W > 0) begin : g_round
            localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC_W - 1);
            logic signed [ACC_W-1:0] biased;
            // Add half an LSB, then drop the fractional bits.
            always_comb begin
                biased = acc + HALF;
                scaled = biased >>> FRAC_W;
            end
        end else begin : g_pass
            // No fractional bits to drop.
            always_comb begin
                scaled = acc;
            end
        end
    endgenerate

    // Clamp to the output range.
    always_comb begin
        if (scaled > MAX_V) begin
            clamped = MAX_V[OUT_W-1:0];
        end else if (scaled < MIN_V) begin
            clamped = MIN_V[OUT_W-1:0];
        end else begin
            clamped = scaled[OUT_W-1:0];
        end
    end

    // Register the result and hold it until the next load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sample <= '0;
            out_valid  <= 1'b0;
        end else begin
            out_valid <= load;
            if (load) begin
                out_sample <= clamped;
            end
        end
    end
endmodule

// File: rtl/interp8_fir.sv
`timescale 1ns/1ps
// Eight-times polyphase interpolating low-pass filter (top level).
// Each output applies the coefficient subset of the current phase to the
// stored real samples, so the zero-stuffed products are never formed.
// Assumes strobes are at least TAPS+1 cycles apart for full throughput,
// that new samples arrive while no run is in progress, and that
// coefficients are not rewritten during a run.
module interp8_fir #(
    parameter int SAMPLE_W = 16,
    parameter int COEF_W   = 16,
    parameter int RATE     = 8,
    parameter int TAPS     = 12,
    parameter int ACC_W    = 40,
    parameter int FRAC_W   = 15,
    localparam int ADDR_W  = $clog2(RATE * TAPS),
    localparam int PH_W    = (RATE > 1) ? $clog2(RATE) : 1,
    localparam int TAP_W   = (TAPS > 1) ? $clog2(TAPS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic                out_strobe,
    output logic [SAMPLE_W-1:0] out_sample,
    output logic                out_valid,
    input  logic                coef_we,
    input  logic [ADDR_W-1:0]   coef_addr,
    input  logic [COEF_W-1:0]   coef_data
);
    logic [PH_W-1:0]            cur_phase;
    logic [PH_W-1:0]            phase_q;
    logic [TAP_W-1:0]           tap_idx;
    logic                       mac_busy;
    logic                       acc_done;
    logic signed [ACC_W-1:0]    acc;
    logic signed [COEF_W-1:0]   coef_rd;
    logic signed [SAMPLE_W-1:0] samp_rd;
    logic signed [SAMPLE_W-1:0] out_s;

    interp8_coef_bank #(
        .COEF_W (COEF_W),
        .RATE   (RATE),
        .TAPS   (TAPS),
        .ADDR_W (ADDR_W),
        .PH_W   (PH_W),
        .TAP_W  (TAP_W)
    ) u_coef (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (coef_we),
        .wr_addr  (coef_addr),
        .wr_data  ($signed(coef_data)),
        .rd_phase (cur_phase),
        .rd_tap   (tap_idx),
        .rd_coef  (coef_rd)
    );

    interp8_delay_line #(
        .SAMPLE_W (SAMPLE_W),
        .TAPS     (TAPS),
        .TAP_W    (TAP_W)
    ) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (in_valid),
        .push_data ($signed(in_sample)),
        .rd_tap    (tap_idx),
        .rd_sample (samp_rd)
    );

    interp8_mac_ctrl #(
        .SAMPLE_W (SAMPLE_W),
        .COEF_W   (COEF_W),
        .RATE     (RATE),
        .TAPS     (TAPS),
        .ACC_W    (ACC_W),
        .PH_W     (PH_W),
        .TAP_W    (TAP_W)
    ) u_mac (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_push    (in_valid),
        .strobe     (out_strobe),
        .sample     (samp_rd),
        .coef       (coef_rd),
        .rd_phase   (cur_phase),
        .next_phase (phase_q),
        .rd_tap     (tap_idx),
        .busy       (mac_busy),
        .acc        (acc),
        .acc_done   (acc_done)
    );

    interp8_round_sat #(
        .ACC_W  (ACC_W),
        .OUT_W  (SAMPLE_W),
        .FRAC_W (FRAC_W)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (acc_done),
        .acc        (acc),
        .out_sample (out_s),
        .out_valid  (out_valid)
    );

    // Pass the signed result to the plain output port.
    always_comb begin
        out_sample = out_s;
    end
endmodule

// File: rtl/interp8_fir_chk.sv
`timescale 1ns/1ps
// Protocol checker for interp8_fir: phase sequencing, run length and
// output pulse timing. Attached to every instance of the top by bind.
module interp8_fir_chk #(
    parameter int RATE  = 8,
    parameter int TAPS  = 12,
    parameter int PH_W  = 3,
    parameter int TAP_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             out_strobe,
    input logic             out_valid,
    input logic             busy,
    input logic [TAP_W-1:0] tap_idx,
    input logic [PH_W-1:0]  phase_q,
    input logic [PH_W-1:0]  cur_phase
);
    logic [PH_W-1:0] phase_step;

    // Expected phase after one step from the present value.
    always_comb begin
        phase_step = (phase_q == PH_W'(RATE - 1)) ? '0 : phase_q + PH_W'(1);
    end

    // R3: a new sample without an accepted strobe rewinds the phase.
    a_r3_push_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !(out_strobe && !busy) |=> phase_q == '0);

    // R4: an accepted strobe without a sample steps the phase by one.
    a_r4_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        out_strobe && !busy && !in_valid |=> phase_q == $past(phase_step));

    // R4: an accepted strobe begins a run at the first tap.
    a_r4_run_starts: assert property (@(posedge clk) disable iff (!rst_n)
        out_strobe && !busy |=> busy && tap_idx == '0);

    // R5: a run ends right after its last tap.
    a_r5_run_length: assert property (@(posedge clk) disable iff (!rst_n)
        busy && tap_idx == TAP_W'(TAPS - 1) |=> !busy);

    // R5: the end of a run is followed by an output pulse.
    a_r5_end_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |=> out_valid);

    // R5: the output pulse lasts a single cycle.
    a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R6: a strobe during a run leaves the selected phase unchanged.
    a_r6_busy_strobe_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        busy && out_strobe |=> $stable(cur_phase));

    // R7: a sample together with an accepted strobe uses phase 0, next is 1.
    a_r7_push_and_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && out_strobe && !busy |=> cur_phase == '0 && phase_q == PH_W'(1 % RATE));
endmodule

bind interp8_fir interp8_fir_chk #(
    .RATE  (RATE),
    .TAPS  (TAPS),
    .PH_W  (PH_W),
    .TAP_W (TAP_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .out_strobe (out_strobe),
    .out_valid  (out_valid),
    .busy       (mac_busy),
    .tap_idx    (tap_idx),
    .phase_q    (phase_q),
    .cur_phase  (cur_phase)
);

// File: tb/tb_interp8_fir.sv
`timescale 1ns/1ps
// Directed bench for interp8_fir: one task per scenario, each checking
// its outputs against an independent model of the requirements.
module tb_interp8_fir;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic        out_strobe = 1'b0;
    logic [15:0] out_sample;
    logic        out_valid;
    logic        coef_we = 1'b0;
    logic [6:0]  coef_addr = '0;
    logic [15:0] coef_data = '0;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    int h_m [96];
    int x_m [12];
    int ph_m = 0;

    interp8_fir dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sample  (in_sample),
        .out_strobe (out_strobe),
        .out_sample (out_sample),
        .out_valid  (out_valid),
        .coef_we    (coef_we),
        .coef_addr  (coef_addr),
        .coef_data  (coef_data)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    function automatic int out_now();
        return int'($signed(out_sample));
    endfunction

    // Model of R4, R8 and R9 for phase p.
    function automatic int model_out(input int p);
        longint s = 0;
        longint r;
        for (int k = 0; k < 12; k++) begin
            s += longint'(h_m[p + 8 * k]) * longint'(x_m[k]);
        end
        r = (s + 64'sd16384) >>> 15;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    task automatic set_coef(input int n, input int v);
        @(negedge clk);
        coef_we   = 1'b1;
        coef_addr = 7'(n);
        coef_data = 16'(v);
        @(negedge clk);
        coef_we = 1'b0;
        if (n < 96) h_m[n] = v;
    endtask

    task automatic model_push(input int v);
        for (int i = 11; i > 0; i--) x_m[i] = x_m[i-1];
        x_m[0] = v;
    endtask

    task automatic push(input int v);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sample = 16'(v);
        @(negedge clk);
        in_valid = 1'b0;
        model_push(v);
        ph_m = 0;
    endtask

    // Wait for the result pulse; return the number of negedges waited.
    task automatic wait_valid(output int n);
        n = 0;
        while (!out_valid && n < 40) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Issue one strobe, check its latency (R5) and its value.
    task automatic fire(input string tag, output int got);
        int n;
        int p = ph_m;
        @(negedge clk);
        out_strobe = 1'b1;
        @(negedge clk);
        out_strobe = 1'b0;
        wait_valid(n);
        check("R5 latency", n, 13);
        got = out_now();
        check(tag, got, model_out(p));
        ph_m = (ph_m + 1) % 8;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        foreach (h_m[i]) h_m[i] = 0;
        foreach (x_m[i]) x_m[i] = 0;
        ph_m = 0;
    endtask

    task automatic load_pattern();
        for (int n = 0; n < 96; n++) set_coef(n, ((n * 37 + 11) % 201) - 100);
    endtask

    task automatic t_reset();
        int g;
        do_reset();
        @(negedge clk);
        check("R1 out_sample after reset", out_now(), 0);
        check("R1 out_valid after reset", int'(out_valid), 0);
        fire("R1 zero output after reset", g);
    endtask

    // R11 and R2: zero-stuffed impulse response through all 96 taps.
    task automatic t_impulse();
        int g;
        load_pattern();
        for (int i = 0; i < 12; i++) push(0);
        push(-32768);
        for (int j = 0; j < 12; j++) begin
            for (int p = 0; p < 8; p++) begin
                fire("R4 impulse output", g);
                check("R11 impulse equals -h[n]", g, -h_m[8 * j + p]);
            end
            push(0);
        end
    endtask

    // R4: phase wraps from 7 to 0 without new input.
    task automatic t_wrap();
        int g;
        push(1000); push(-2500); push(7000);
        for (int i = 0; i < 10; i++) fire("R4 phase wrap", g);
    endtask

    // R3: a new sample rewinds the phase.
    task automatic t_push_phase();
        int g;
        fire("R4 before push", g);
        fire("R4 before push", g);
        fire("R4 before push", g);
        push(12000);
        fire("R3 phase rewound to 0", g);
    endtask

    // R6: strobe during a run is ignored; R5 output holds.
    task automatic t_busy_strobe();
        int n;
        int g;
        int extra = 0;
        int p = ph_m;
        @(negedge clk);
        out_strobe = 1'b1;
        @(negedge clk);
        out_strobe = 1'b0;
        repeat (4) @(negedge clk);
        out_strobe = 1'b1;
        @(negedge clk);
        out_strobe = 1'b0;
        n = 0;
        while (!out_valid && n < 40) begin
            @(negedge clk);
            n++;
        end
        g = out_now();
        check("R6 first run value", g, model_out(p));
        ph_m = (ph_m + 1) % 8;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (out_valid) extra++;
        end
        check("R6 no extra output", extra, 0);
        check("R5 output holds", out_now(), g);
        fire("R6 phase advanced once", g);
    endtask

    // R7: sample and strobe in the same cycle.
    task automatic t_same_cycle();
        int n;
        int g;
        fire("R4 before same-cycle", g);
        fire("R4 before same-cycle", g);
        @(negedge clk);
        in_valid   = 1'b1;
        in_sample  = 16'(-9000);
        out_strobe = 1'b1;
        @(negedge clk);
        in_valid   = 1'b0;
        out_strobe = 1'b0;
        model_push(-9000);
        wait_valid(n);
        check("R7 latency", n, 13);
        check("R7 new sample at phase 0", out_now(), model_out(0));
        ph_m = 1;
        fire("R7 next phase is 1", g);
    endtask

    // R2: writes beyond index 95 change nothing.
    task automatic t_bad_addr();
        int g;
        set_coef(100, 30000);
        set_coef(127, -30000);
        set_coef(96, 25000);
        push(20000);
        for (int p = 0; p < 8; p++) fire("R2 out-of-range write ignored", g);
    endtask

    // R10: unity gain on a constant input.
    task automatic t_dc();
        int g;
        for (int n = 0; n < 96; n++) set_coef(n, (n < 32) ? 8192 : 0);
        for (int i = 0; i < 12; i++) push(12345);
        for (int p = 0; p < 8; p++) begin
            fire("R10 model", g);
            check("R10 constant reproduced", g, 12345);
        end
        for (int i = 0; i < 12; i++) push(-20000);
        for (int p = 0; p < 8; p++) begin
            fire("R10 model", g);
            check("R10 negative constant reproduced", g, -20000);
        end
    endtask

    // R8: round half toward positive infinity.
    task automatic t_round();
        int g;
        for (int n = 0; n < 96; n++) set_coef(n, 0);
        set_coef(0, 1);
        push(16384);  fire("R8 model", g); check("R8 half rounds up", g, 1);
        push(16383);  fire("R8 model", g); check("R8 below half rounds down", g, 0);
        push(-16384); fire("R8 model", g); check("R8 negative half rounds up", g, 0);
        push(-16385); fire("R8 model", g); check("R8 below negative half", g, -1);
    endtask

    // R9: saturation in both directions.
    task automatic t_sat();
        int g;
        for (int n = 0; n < 96; n++) set_coef(n, 32767);
        for (int i = 0; i < 12; i++) push(32767);
        fire("R9 model", g);
        check("R9 positive clamp", g, 32767);
        for (int i = 0; i < 12; i++) push(-32768);
        fire("R9 model", g);
        check("R9 negative clamp", g, -32768);
    endtask

    initial begin
        t_reset();
        t_impulse();
        t_wrap();
        t_push_phase();
        t_busy_strobe();
        t_same_cycle();
        t_bad_addr();
        t_dc();
        t_round();
        t_sat();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule